// File: doc/BRIEF.md
# Maskable I/O Port Decode Filter

This block sits between a CPU I/O bus and a group of internal peripherals. It compares each 16-bit I/O port address against a fixed set of internal port numbers and raises one select line per peripheral group. Each select is gated by a stored enable bit. When an expansion bus is attached and switched on, the select is also gated by a stored expansion mask bit. A cycle that no enabled internal device claims is offered to the expansion bus, but only while that bus is on. When the bus is off, such cycles are dropped.

Two 32-bit words are kept: an enable word and an expansion mask word. Software reaches each word through four byte-wide registers. A hard-reset or soft-reset request presets a word to all ones, or leaves it untouched. The choice depends on the word's own top bit, so software can choose which kind of reset clears its settings. Writes that come from the display coprocessor are refused. The peripherals themselves are outside the block.

Top module: `io_port_gate`

## Requirements
- R1: After `rst_n` is released, every one of the eight byte registers reads 0xFF.
- R2: `reg_sel` values 0..3 address enable-word bytes 0..3, and 4..7 address mask-word bytes 0..3. Byte k holds word bits 8k+7..8k. A write with `reg_wr` high is stored at the clock edge. `reg_rdata` always shows the byte that `reg_sel` currently addresses.
- R3: A write with `reg_from_cop` high leaves both words unchanged.
- R4: A write in a cycle where `hard_rst` or `soft_rst` is high is discarded.
- R5: On a `hard_rst` cycle, a word whose bit 31 is 1 becomes all ones at the next edge. A word whose bit 31 is 0 keeps its value.
- R6: On a `soft_rst` cycle, a word whose bit 31 is 0 becomes all ones at the next edge. A word whose bit 31 is 1 keeps its value.
- R7: `dev_sel[d]` belongs to word bit 8+d. The ports for each d are:
  - d=0: low address byte 0xE3
  - d=2: 0x103B, 0x113B
  - d=3: low bytes 0xE7, 0xEB
  - d=4: 0x133B, 0x143B, 0x153B
  - d=5: 0xFADF, 0xFBDF, 0xFFDF
  - d=6: low bytes 0x57, 0x5B, and full address 0x303B
  - d=7: 0x123B
- R8: `dev_sel[1]` responds to the full addresses on `alt_port_a` and `alt_port_b`.
- R9: With `bus_on` low, a device's effective enable is its enable bit alone, and the mask word has no effect.
- R10: With `bus_on` high, a device's effective enable is its enable bit AND its mask bit.
- R11: `dev_sel[d]` is high in the same cycle exactly when `io_rd` or `io_wr` is high, the address matches device d, and d is effectively enabled.
- R12: `exp_fwd` is high in the same cycle exactly when `bus_on` is high, a strobe is high, and no effectively enabled device matches the address. This includes addresses that match no port at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously upstream |
| hard_rst | input | 1 | Hard-reset request, one cycle |
| soft_rst | input | 1 | Soft-reset request, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_from_cop | input | 1 | Marks the write as coming from the display coprocessor |
| reg_sel | input | 3 | Byte register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` |
| bus_on | input | 1 | Expansion bus enabled |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| alt_port_a | input | 16 | First configurable port of device 1 |
| alt_port_b | input | 16 | Second configurable port of device 1 |
| dev_sel | output | 8 | Per-device select |
| exp_fwd | output | 1 | Forward the cycle to the expansion bus |

## Verification
The only state is the two stored words, and any corruption of them shows up on the very next cycle in two places. It appears on `reg_rdata` for the addressed byte. It also appears on `dev_sel` and `exp_fwd` for any address that maps to the corrupted bit. The bench therefore compares all three outputs against a behavioural model on every clock. A wrong reset decision or an accepted forbidden write is exposed one edge later, and a decode error is exposed in the same cycle as the address.

// File: rtl/iopg_pkg.sv
`timescale 1ns/1ps
package iopg_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DEV_BASE   = 8;
  localparam int unsigned NUM_DEV    = 8;

  // device index = word bit minus DEV_BASE
  localparam int unsigned DEV_DIVCTL = 0;
  localparam int unsigned DEV_ALT    = 1;
  localparam int unsigned DEV_LAYER  = 2;
  localparam int unsigned DEV_SERIAL = 3;
  localparam int unsigned DEV_UART   = 4;
  localparam int unsigned DEV_MOUSE  = 5;
  localparam int unsigned DEV_SPRITE = 6;
  localparam int unsigned DEV_LAYER2 = 7;

  typedef logic [15:0] io_addr_t;
endpackage

// File: rtl/iopg_regs.sv
`timescale 1ns/1ps
module iopg_regs #(
  parameter int unsigned BYTES    = 4,
  parameter int unsigned DEV_BASE = 8,
  parameter int unsigned NUM_DEV  = 8,
  localparam int unsigned W       = BYTES * 8,
  localparam int unsigned BW      = $clog2(BYTES),
  localparam int unsigned SELW    = BW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hard_rst,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic                wr_cop,
  input  logic [SELW-1:0]     sel,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NUM_DEV-1:0]  en_dev,
  output logic [NUM_DEV-1:0]  mask_dev
);
  logic [1:0][W-1:0] word_q;
  logic [1:0][W-1:0] word_d;
  logic [1:0]        word_upd;
  logic              wr_ok;
  logic              bank;
  logic [BW-1:0]     byte_idx;

  assign bank     = sel[SELW-1];
  assign byte_idx = sel[BW-1:0];
  assign wr_ok    = wr_en && !wr_cop && !hard_rst && !soft_rst;

  for (genvar g = 0; g < 2; g++) begin : g_word
    logic preset;
    logic wr_hit;

    assign preset = (hard_rst &&  word_q[g][W-1]) ||
                    (soft_rst && !word_q[g][W-1]);
    assign wr_hit = wr_ok && (bank == g[0]);

    always_comb begin
      word_d[g]   = word_q[g];
      word_upd[g] = preset || wr_hit;
      if (preset) begin
        word_d[g] = '1;
      end else if (wr_hit) begin
        for (int b = 0; b < BYTES; b++) begin
          if (byte_idx == b[BW-1:0]) word_d[g][b*8 +: 8] = wdata;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '1;
      end else if (word_upd[g]) begin
        word_q[g] <= word_d[g];
      end
    end

    AST_HARD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst && !soft_rst && word_q[g][W-1] |=> word_q[g] == '1); // R5
    AST_HARD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst && !soft_rst && !word_q[g][W-1] |=> $stable(word_q[g])); // R5
    AST_SOFT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst && !hard_rst && !word_q[g][W-1] |=> word_q[g] == '1); // R6
    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst && !hard_rst && word_q[g][W-1] |=> $stable(word_q[g])); // R6
    AST_COP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_cop && !hard_rst && !soft_rst |=> $stable(word_q[g])); // R3
  end

  assign rdata    = word_q[bank][byte_idx*8 +: 8];
  assign en_dev   = word_q[0][DEV_BASE +: NUM_DEV];
  assign mask_dev = word_q[1][DEV_BASE +: NUM_DEV];
endmodule

// File: rtl/iopg_decode.sv
`timescale 1ns/1ps
module iopg_decode
  import iopg_pkg::*;
#(
  parameter int unsigned N = NUM_DEV
) (
  input  io_addr_t       addr,
  input  io_addr_t       alt_a,
  input  io_addr_t       alt_b,
  output logic [N-1:0]   hit
);
  logic [7:0] lo;
  assign lo = addr[7:0];

  always_comb begin
    hit             = '0;
    hit[DEV_DIVCTL] = (lo == 8'hE3);
    hit[DEV_ALT]    = (addr == alt_a) || (addr == alt_b);
    hit[DEV_LAYER]  = (addr == 16'h103B) || (addr == 16'h113B);
    hit[DEV_SERIAL] = (lo == 8'hE7) || (lo == 8'hEB);
    hit[DEV_UART]   = (addr == 16'h133B) || (addr == 16'h143B) ||
                      (addr == 16'h153B);
    hit[DEV_MOUSE]  = (addr == 16'hFADF) || (addr == 16'hFBDF) ||
                      (addr == 16'hFFDF);
    hit[DEV_SPRITE] = (lo == 8'h57) || (lo == 8'h5B) || (addr == 16'h303B);
    hit[DEV_LAYER2] = (addr == 16'h123B);
  end
endmodule

// File: rtl/io_port_gate.sv
`timescale 1ns/1ps
module io_port_gate
  import iopg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hard_rst,
  input  logic        soft_rst,
  input  logic        reg_wr,
  input  logic        reg_from_cop,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        bus_on,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [15:0] alt_port_a,
  input  logic [15:0] alt_port_b,
  output logic [7:0]  dev_sel,
  output logic        exp_fwd
);
  logic [NUM_DEV-1:0] en_dev;
  logic [NUM_DEV-1:0] mask_dev;
  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] eff_en;
  logic [NUM_DEV-1:0] claim;
  logic               cyc;

  iopg_regs #(
    .BYTES(WORD_BYTES), .DEV_BASE(DEV_BASE), .NUM_DEV(NUM_DEV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .wr_en(reg_wr), .wr_cop(reg_from_cop), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .en_dev(en_dev), .mask_dev(mask_dev)
  );

  iopg_decode #(.N(NUM_DEV)) u_dec (
    .addr(io_addr), .alt_a(alt_port_a), .alt_b(alt_port_b), .hit(hit)
  );

  assign cyc     = io_rd || io_wr;
  assign eff_en  = bus_on ? (en_dev & mask_dev) : en_dev;
  assign claim   = hit & eff_en;
  assign dev_sel = cyc ? claim : '0;
  assign exp_fwd = cyc && bus_on && (claim == '0);

  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel != '0) |-> cyc); // R11
  AST_SEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel & ~en_dev) == '0); // R9
  AST_SEL_MASKED_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_on |-> (dev_sel & ~mask_dev) == '0); // R10
  AST_SEL_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel & ~hit) == '0); // R7
  AST_FWD_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    exp_fwd |-> bus_on && cyc); // R12
  AST_FWD_NOT_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    exp_fwd |-> dev_sel == '0); // R12
endmodule

// File: tb/io_port_gate_test.sv
`timescale 1ns/1ps
module io_port_gate_test;
  logic        clk = 1'b0;
  logic        rst_n, hard_rst, soft_rst, reg_wr, reg_from_cop;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        bus_on, io_rd, io_wr, exp_fwd;
  logic [15:0] io_addr, alt_port_a, alt_port_b;
  logic [7:0]  dev_sel;

  int    total = 0;
  int    bad   = 0;
  string req_tag = "R1";

  always #2 clk = ~clk;

  io_port_gate uut (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_from_cop(reg_from_cop), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_on(bus_on),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .alt_port_a(alt_port_a), .alt_port_b(alt_port_b),
    .dev_sel(dev_sel), .exp_fwd(exp_fwd)
  );

  // behavioural reference state
  logic [31:0] m_en, m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en   <= 32'hFFFF_FFFF;
      m_mask <= 32'hFFFF_FFFF;
    end else begin
      logic [31:0] ne, nm;
      ne = m_en;
      nm = m_mask;
      if ((hard_rst && m_en[31]) || (soft_rst && !m_en[31]))     ne = '1;
      if ((hard_rst && m_mask[31]) || (soft_rst && !m_mask[31])) nm = '1;
      if (reg_wr && !reg_from_cop && !hard_rst && !soft_rst) begin
        if (reg_sel < 4) ne[reg_sel*8 +: 8] = reg_wdata;
        else             nm[(reg_sel-4)*8 +: 8] = reg_wdata;
      end
      m_en   <= ne;
      m_mask <= nm;
    end
  end

  function automatic logic [7:0] ref_hits(input logic [15:0] a,
                                          input logic [15:0] pa,
                                          input logic [15:0] pb);
    logic [7:0] h = '0;
    case (a[7:0])
      8'hE3:        h[0] = 1'b1;
      8'hE7, 8'hEB: h[3] = 1'b1;
      8'h57, 8'h5B: h[6] = 1'b1;
      default: ;
    endcase
    case (a)
      16'h103B, 16'h113B:           h[2] = 1'b1;
      16'h133B, 16'h143B, 16'h153B: h[4] = 1'b1;
      16'hFADF, 16'hFBDF, 16'hFFDF: h[5] = 1'b1;
      16'h303B:                     h[6] = 1'b1;
      16'h123B:                     h[7] = 1'b1;
      default: ;
    endcase
    if (a == pa || a == pb) h[1] = 1'b1;
    return h;
  endfunction

  always @(negedge clk) begin
    logic [7:0] exp_rd, exp_sel, eff, h;
    logic       exp_f;
    exp_rd  = (reg_sel < 4) ? m_en[reg_sel*8 +: 8] : m_mask[(reg_sel-4)*8 +: 8];
    eff     = bus_on ? (m_en[15:8] & m_mask[15:8]) : m_en[15:8];
    h       = ref_hits(io_addr, alt_port_a, alt_port_b);
    exp_sel = (io_rd || io_wr) ? (h & eff) : 8'h00;
    exp_f   = (io_rd || io_wr) && bus_on && ((h & eff) == 8'h00);
    total += 3;
    if (reg_rdata !== exp_rd) begin
      bad++;
      $display("FAIL %s rdata sel=%0d act=%h exp=%h", req_tag, reg_sel, reg_rdata, exp_rd);
    end
    if (dev_sel !== exp_sel) begin
      bad++;
      $display("FAIL %s dev_sel addr=%h act=%b exp=%b", req_tag, io_addr, dev_sel, exp_sel);
    end
    if (exp_fwd !== exp_f) begin
      bad++;
      $display("FAIL %s exp_fwd addr=%h act=%b exp=%b", req_tag, io_addr, exp_fwd, exp_f);
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #80000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input logic cop);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1; reg_from_cop = cop;
    tick();
    reg_wr = 1'b0; reg_from_cop = 1'b0;
  endtask

  task automatic read_all();
    for (int s = 0; s < 8; s++) begin
      reg_sel = s[2:0];
      tick();
    end
  endtask

  task automatic sweep();
    logic [15:0] list [26] = '{16'h00E3, 16'h7FE3, 16'h103B, 16'h113B,
      16'h12E7, 16'hFFEB, 16'h133B, 16'h143B, 16'h153B, 16'hFADF,
      16'hFBDF, 16'hFFDF, 16'h0057, 16'hA55B, 16'h303B, 16'h123B,
      16'h2A3F, 16'h00C5, 16'h0000, 16'h123C, 16'h203B, 16'hFCDF,
      16'h163B, 16'h00E4, 16'h0058, 16'hFFFF};
    for (int i = 0; i < 26; i++) begin
      io_addr = list[i];
      io_rd   = i[0];
      io_wr   = !i[0];
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; hard_rst = 1'b0; soft_rst = 1'b0; reg_wr = 1'b0;
    reg_from_cop = 1'b0; reg_sel = '0; reg_wdata = '0; bus_on = 1'b0;
    io_addr = '0; io_rd = 1'b0; io_wr = 1'b0;
    alt_port_a = 16'h2A3F; alt_port_b = 16'h00C5;
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: reset values
    read_all();

    // R2: write and read back every byte
    req_tag = "R2";
    for (int s = 0; s < 8; s++) wr(s[2:0], 8'h13 + 8'h29 * s[7:0], 1'b0);
    read_all();

    // R3: coprocessor writes refused
    req_tag = "R3";
    for (int s = 0; s < 8; s++) wr(s[2:0], 8'hC6 ^ s[7:0], 1'b1);
    read_all();

    // R4: writes during reset requests discarded
    req_tag = "R4";
    wr(3, 8'h00, 1'b0); wr(7, 8'h80, 1'b0);
    hard_rst = 1'b1; wr(1, 8'h42, 1'b0); hard_rst = 1'b0;
    soft_rst = 1'b1; wr(5, 8'h24, 1'b0); soft_rst = 1'b0;
    read_all();

    // R5: hard reset presets words with bit 31 set only
    req_tag = "R5";
    wr(3, 8'h80, 1'b0); wr(1, 8'h00, 1'b0);
    wr(7, 8'h00, 1'b0); wr(5, 8'h5A, 1'b0);
    hard_rst = 1'b1; tick(); hard_rst = 1'b0;
    read_all();

    // R6: soft reset presets words with bit 31 clear only
    req_tag = "R6";
    wr(1, 8'h00, 1'b0); wr(3, 8'h80, 1'b0);
    wr(4, 8'h00, 1'b0); wr(7, 8'h00, 1'b0);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    read_all();

    // R7: full port map, all enabled, bus off
    req_tag = "R7";
    wr(1, 8'hFF, 1'b0); wr(5, 8'h00, 1'b0);
    sweep();

    // R8: configurable ports, then device 1 disabled
    req_tag = "R8";
    alt_port_a = 16'h4E3B; alt_port_b = 16'h00C5;
    sweep();
    wr(1, 8'hFD, 1'b0);
    sweep();

    // R9: bus off ignores mask
    req_tag = "R9";
    wr(1, 8'hA5, 1'b0); wr(5, 8'h00, 1'b0);
    sweep();

    // R10: bus on gates with mask
    req_tag = "R10";
    bus_on = 1'b1;
    wr(1, 8'hF0, 1'b0); wr(5, 8'h3C, 1'b0);
    sweep();

    // R11: no strobe, no select
    req_tag = "R11";
    wr(1, 8'hFF, 1'b0); wr(5, 8'hFF, 1'b0);
    for (int i = 0; i < 4; i++) begin
      io_addr = (i == 0) ? 16'h123B : (i == 1) ? 16'h00E3 : (i == 2) ? 16'hFFDF : 16'h0000;
      io_rd = 1'b0; io_wr = 1'b0;
      tick();
    end

    // R12: forwarding with bus on, none with bus off
    req_tag = "R12";
    wr(5, 8'h55, 1'b0);
    sweep();
    bus_on = 1'b0;
    wr(1, 8'h00, 1'b0);
    sweep();
    io_rd = 1'b0; io_wr = 1'b0;
    tick();
    finish_run();
  end
endmodule